// File: doc/BRIEF.md
# Multi-mode 8-bit timer with compare waveform

This block is an 8-bit timer/counter with one compare channel. A single control register picks one of four counting patterns: a free-running up count, a clear-on-compare count, a single-slope pulse-width pattern and a dual-slope (up then down) pulse-width pattern. The same register picks the compare output action and gates counting on or off. The counter advances on cycles where the `tick` input is high and counting is enabled. When the count equals the active compare value, the block raises a compare flag and updates a single waveform output. An overflow flag marks the end point of each counting pattern.

The compare value has two copies: a buffer, written by software, and an active copy, used for matching. In the two pulse-width modes the buffer moves into the active copy only at a fixed point in the count, so a new duty cycle never splits a period. A one-shot force bit in the control register applies the compare output action at once, without any side effect. A `pin_override` output tells the surrounding pin multiplexer that the waveform owns the pin.

Registers are reached through a simple one-cycle write port and a combinational read port. The address map is: 0 control, 1 counter, 2 compare (reads return the buffer), 3 flags.

Top module: `wave_timer8`

## Requirements
- R1: After reset every register reads 0, `wave_out` and `pin_override` are low, and the counter holds while control bits 2:0 (count enable) are all zero, even when `tick` is high.
- R2: The counter steps only on a cycle where `tick` is high and control bits 2:0 are nonzero. In the free-running mode (control bit 3 = 0, bit 6 = 0) it goes 0x00 up to 0xFF and wraps to 0x00. The overflow flag (flags bit 0) is set by the step that starts from 0xFF.
- R3: The mode is the 2-bit value {control bit 3, control bit 6}: 00 free-running, 01 dual-slope PWM, 10 clear-on-compare, 11 single-slope PWM. In clear-on-compare mode, a step that starts from a count equal to the compare value loads 0x00 and sets the compare flag (flags bit 1). The sequence therefore has period compare+1.
- R4: In dual-slope PWM the counter runs 0x00 up to 0xFF, then down to 0x00, and turns at each end without repeating the end value. Its overflow flag is set by each step that starts from 0x00.
- R5: In single-slope PWM the counter runs 0x00 up to 0xFF and wraps to 0x00. The overflow flag is set by the step that starts from 0xFF.
- R6: In the free-running and clear-on-compare modes, a compare write takes effect at once. In dual-slope PWM the buffer is copied to the active value on the step that starts from 0xFF. In single-slope PWM it is copied on the step that wraps to 0x00. A read of address 2 returns the buffer.
- R7: In free-running and clear-on-compare modes, control bits 5:4 act on a compare match as follows: 00 no effect, 01 toggle `wave_out`, 10 drive it low, 11 drive it high.
- R8: In single-slope PWM, output action 10 drives `wave_out` low on a match and high on the wrap to 0x00, and 11 does the reverse. In dual-slope PWM, action 10 drives it low on a match while counting up and high on a match while counting down, and 11 does the reverse. Action 01 has no effect in either PWM mode.
- R9: A control write with bit 7 set, whose written mode is non-PWM, applies the written output action to `wave_out` at once. It neither sets the compare flag nor changes the counter. When the written mode is a PWM mode, bit 7 is ignored. Bit 7 always reads back as 0.
- R10: `pin_override` is high exactly when control bits 5:4 are not 00.
- R11: A write to the counter (address 1) takes priority over a step in the same cycle. It also suppresses any compare match on the next step.
- R12: The flags are cleared by writing 1 to their bit at address 3 (bit 0 overflow, bit 1 compare). A set event in the same cycle wins over the clear. `ovf_irq` and `cmp_irq` show the flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Count-enable pulse; the counter steps on cycles where it is high |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address (0 control, 1 counter, 2 compare, 3 flags) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr`, combinational |
| wave_out | output | 1 | Compare waveform output |
| pin_override | output | 1 | High when the waveform should replace port data |
| ovf_irq | output | 1 | Overflow flag |
| cmp_irq | output | 1 | Compare flag |

## Verification
Two events that can land in the same cycle are a counter write and a step that would otherwise match. The bench loads the counter with the compare value, then steps once. It expects the count to move on by one, with no clear and no compare flag. A second collision is a forced compare and the counter/flag state. The bench reads the count and flags before and after a force write, and expects only `wave_out` to change. In a PWM mode it expects even that to stay put. The pulse-width waveforms are swept over whole periods, and each output sample is compared with a threshold on the expected count.

// File: rtl/wt_pkg.sv
package wt_pkg;
    localparam int BUS_W = 8;

    typedef enum logic [1:0] {
        MODE_FREE  = 2'b00,
        MODE_DUAL  = 2'b01,
        MODE_CLEAR = 2'b10,
        MODE_FAST  = 2'b11
    } wt_mode_e;

    localparam int CTL_FORCE   = 7;
    localparam int CTL_MODE_LO = 6;
    localparam int CTL_ACT_HI  = 5;
    localparam int CTL_ACT_LO  = 4;
    localparam int CTL_MODE_HI = 3;

    localparam logic [1:0] ADDR_CTL = 2'd0;
    localparam logic [1:0] ADDR_CNT = 2'd1;
    localparam logic [1:0] ADDR_CMP = 2'd2;
    localparam logic [1:0] ADDR_FLG = 2'd3;
endpackage

// File: rtl/wt_count.sv
module wt_count
    import wt_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  wt_mode_e     mode,
    input  logic         step,
    input  logic         cnt_wr,
    input  logic         cmp_wr,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] cnt,
    output logic [W-1:0] cmp_buf,
    output logic         hit,
    output logic         ovf_evt,
    output logic         wrap_evt,
    output logic         down
);
    localparam logic [W-1:0] MAXV = {W{1'b1}};
    localparam logic [W-1:0] ONE  = {{(W-1){1'b0}}, 1'b1};

    typedef struct packed {
        logic [W-1:0] cnt;
        logic [W-1:0] buf_v;
        logic [W-1:0] act;
        logic         dn;
        logic         block;
    } cnt_s;

    cnt_s st_q, st_d;
    logic at_max, at_min, imm;

    always_comb begin
        st_d     = st_q;
        at_max   = (st_q.cnt == MAXV);
        at_min   = (st_q.cnt == '0);
        imm      = (mode == MODE_FREE) || (mode == MODE_CLEAR);
        hit      = step && !st_q.block && (st_q.cnt == st_q.act);
        ovf_evt  = step && ((mode == MODE_DUAL) ? at_min : at_max);
        wrap_evt = step && (mode == MODE_FAST) && at_max;

        if (step) begin
            st_d.block = 1'b0;
            case (mode)
                MODE_CLEAR: st_d.cnt = hit ? '0 : st_q.cnt + ONE;
                MODE_FAST: begin
                    st_d.cnt = st_q.cnt + ONE;
                    if (at_max) st_d.act = st_q.buf_v;
                end
                MODE_DUAL: begin
                    if (!st_q.dn) begin
                        if (at_max) begin
                            st_d.dn  = 1'b1;
                            st_d.cnt = st_q.cnt - ONE;
                            st_d.act = st_q.buf_v;
                        end else begin
                            st_d.cnt = st_q.cnt + ONE;
                        end
                    end else if (at_min) begin
                        st_d.dn  = 1'b0;
                        st_d.cnt = ONE;
                    end else begin
                        st_d.cnt = st_q.cnt - ONE;
                    end
                end
                default: st_d.cnt = st_q.cnt + ONE;
            endcase
        end
        if (mode != MODE_DUAL) st_d.dn = 1'b0;
        if (cmp_wr) st_d.buf_v = wdata;
        if (imm) st_d.act = st_d.buf_v;
        if (cnt_wr) begin
            st_d.cnt   = wdata;
            st_d.block = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt     = st_q.cnt;
    assign cmp_buf = st_q.buf_v;
    assign down    = st_q.dn;

    assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !cnt_wr) |=> $stable(cnt));
    assert_clear_on_hit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_CLEAR && hit && !cnt_wr) |=> (cnt == '0));
    assert_dual_turn_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_DUAL && step && !cnt_wr && cnt == MAXV) |=> (cnt == MAXV - ONE && down));
    assert_write_blocks_R11: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_wr |=> !hit);
endmodule

// File: rtl/wt_wave.sv
module wt_wave
    import wt_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  wt_mode_e   mode,
    input  logic [1:0] act,
    input  logic       hit,
    input  logic       down,
    input  logic       wrap_evt,
    input  logic       force_evt,
    input  logic [1:0] force_act,
    output logic       wave
);
    typedef struct packed {
        logic wave;
    } wave_s;

    wave_s st_q, st_d;

    function automatic logic apply_act(input logic cur, input logic [1:0] a);
        case (a)
            2'b01:   return ~cur;
            2'b10:   return 1'b0;
            2'b11:   return 1'b1;
            default: return cur;
        endcase
    endfunction

    always_comb begin
        st_d = st_q;
        case (mode)
            MODE_FAST: begin
                if (act[1]) begin
                    if (wrap_evt)  st_d.wave = ~act[0];
                    else if (hit)  st_d.wave = act[0];
                end
            end
            MODE_DUAL: begin
                if (act[1] && hit) st_d.wave = down ? ~act[0] : act[0];
            end
            default: begin
                if (hit) st_d.wave = apply_act(st_q.wave, act);
            end
        endcase
        if (force_evt) st_d.wave = apply_act(st_d.wave, force_act);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign wave = st_q.wave;

    assert_fast_bottom_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_FAST && act == 2'b10 && wrap_evt && !force_evt) |=> wave);
    assert_clear_act_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_CLEAR && act == 2'b10 && hit && !force_evt) |=> !wave);
endmodule

// File: rtl/wave_timer8.sv
module wave_timer8
    import wt_pkg::*;
#(
    parameter int W = BUS_W
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       reg_wr,
    input  logic [1:0] reg_addr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    output logic       wave_out,
    output logic       pin_override,
    output logic       ovf_irq,
    output logic       cmp_irq
);
    typedef struct packed {
        logic [6:0] ctl;
        logic       ovf;
        logic       cmp;
    } top_s;

    top_s st_q, st_d;

    wt_mode_e     mode;
    logic         step, wr_ctl, wr_cnt, wr_cmp, wr_flg, force_evt;
    logic [W-1:0] cnt, cmp_buf;
    logic         hit, ovf_evt, wrap_evt, down;

    always_comb begin
        st_d      = st_q;
        mode      = wt_mode_e'({st_q.ctl[CTL_MODE_HI], st_q.ctl[CTL_MODE_LO]});
        step      = tick && (st_q.ctl[2:0] != 3'b000);
        wr_ctl    = reg_wr && (reg_addr == ADDR_CTL);
        wr_cnt    = reg_wr && (reg_addr == ADDR_CNT);
        wr_cmp    = reg_wr && (reg_addr == ADDR_CMP);
        wr_flg    = reg_wr && (reg_addr == ADDR_FLG);
        force_evt = wr_ctl && reg_wdata[CTL_FORCE] && !reg_wdata[CTL_MODE_LO];

        if (wr_ctl) st_d.ctl = reg_wdata[6:0];
        st_d.ovf = (st_q.ovf && !(wr_flg && reg_wdata[0])) || ovf_evt;
        st_d.cmp = (st_q.cmp && !(wr_flg && reg_wdata[1])) || hit;

        reg_rdata = '0;
        case (reg_addr)
            ADDR_CTL: reg_rdata = {1'b0, st_q.ctl};
            ADDR_CNT: reg_rdata[W-1:0] = cnt;
            ADDR_CMP: reg_rdata[W-1:0] = cmp_buf;
            default:  reg_rdata = {6'd0, st_q.cmp, st_q.ovf};
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    wt_count #(.W(W)) i_count (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode     (mode),
        .step     (step),
        .cnt_wr   (wr_cnt),
        .cmp_wr   (wr_cmp),
        .wdata    (reg_wdata[W-1:0]),
        .cnt      (cnt),
        .cmp_buf  (cmp_buf),
        .hit      (hit),
        .ovf_evt  (ovf_evt),
        .wrap_evt (wrap_evt),
        .down     (down)
    );

    wt_wave i_wave (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode      (mode),
        .act       (st_q.ctl[CTL_ACT_HI:CTL_ACT_LO]),
        .hit       (hit),
        .down      (down),
        .wrap_evt  (wrap_evt),
        .force_evt (force_evt),
        .force_act (reg_wdata[CTL_ACT_HI:CTL_ACT_LO]),
        .wave      (wave_out)
    );

    assign pin_override = |st_q.ctl[CTL_ACT_HI:CTL_ACT_LO];
    assign ovf_irq      = st_q.ovf;
    assign cmp_irq      = st_q.cmp;

    assert_ovf_set_R12: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_evt |=> ovf_irq);
    assert_cmp_set_R12: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> cmp_irq);
    assert_force_no_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (force_evt && !hit && !cmp_irq) |=> !cmp_irq);
    assert_force_pwm_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctl && reg_wdata[CTL_MODE_LO] && st_q.ctl[CTL_MODE_LO] && !hit && !wrap_evt)
        |=> $stable(wave_out));
    assert_override_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctl && reg_wdata[5:4] == 2'b00) |=> !pin_override);
endmodule

// File: tb/test_wave_timer8.sv
`timescale 1ns/1ps
module test_wave_timer8;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       reg_wr = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [7:0] reg_wdata = 8'd0;
    logic [7:0] reg_rdata;
    logic       wave_out, pin_override, ovf_irq, cmp_irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    wave_timer8 i_wave_timer8 (
        .clk(clk), .rst_n(rst_n), .tick(tick), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .wave_out(wave_out), .pin_override(pin_override),
        .ovf_irq(ovf_irq), .cmp_irq(cmp_irq)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk);
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic steps(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            tick = 1'b1;
            @(posedge clk);
            @(negedge clk);
            tick = 1'b0;
        end
    endtask

    function automatic int dual_cnt(input int k);
        int p = k % 510;
        return (p <= 255) ? p : 510 - p;
    endfunction

    initial begin
        logic [7:0] v, v2;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        for (int a = 0; a < 4; a++) begin
            rd(a[1:0], v);
            chk(v == 8'h00, "R1 reset register", v, 0);
        end
        chk(wave_out == 1'b0, "R1 reset wave", wave_out, 0);
        chk(pin_override == 1'b0, "R1 reset override", pin_override, 0);
        steps(5);
        rd(ADDR_CNT_T, v);
        chk(v == 8'h00, "R1 count held while disabled", v, 0);

        // R2: free-running count and overflow point
        wr(0, 8'h01);
        for (int k = 1; k <= 300; k++) begin
            steps(1);
            rd(1, v);
            chk(v == 8'(k % 256), "R2 free-running count", v, k % 256);
            if (k == 255) chk(ovf_irq == 1'b0, "R2 no overflow before 0xFF step", ovf_irq, 0);
            if (k == 256) chk(ovf_irq == 1'b1, "R2 overflow at 0xFF step", ovf_irq, 1);
        end
        // R12: write-one-to-clear
        wr(3, 8'h03);
        rd(3, v);
        chk(v == 8'h00, "R12 flags cleared", v, 0);

        // R3: clear-on-compare, period compare+1
        wr(0, 8'h09);
        wr(2, 8'h05);
        wr(1, 8'h00);
        wr(3, 8'h03);
        for (int k = 1; k <= 18; k++) begin
            steps(1);
            rd(1, v);
            chk(v == 8'(k % 6), "R3 clear-on-compare count", v, k % 6);
            if (k == 5) chk(cmp_irq == 1'b0, "R3 compare flag before match", cmp_irq, 0);
            if (k == 6) chk(cmp_irq == 1'b1, "R3 compare flag on match", cmp_irq, 1);
        end

        // R6: immediate compare update
        wr(2, 8'h03);
        rd(2, v);
        chk(v == 8'h03, "R6 compare read-back", v, 3);
        wr(1, 8'h00);
        for (int k = 1; k <= 8; k++) begin
            steps(1);
            rd(1, v);
            chk(v == 8'(k % 4), "R6 immediate compare period", v, k % 4);
        end

        // R9: force clear, no counter/flag side effects
        wr(3, 8'h03);
        rd(1, v);
        wr(0, 8'hA9);
        chk(wave_out == 1'b0, "R9 force clear", wave_out, 0);
        rd(1, v2);
        chk(v2 == v, "R9 force leaves counter", v2, v);
        chk(cmp_irq == 1'b0, "R9 force sets no flag", cmp_irq, 0);
        rd(0, v);
        chk(v == 8'h29, "R9 force bit reads 0", v, 8'h29);
        chk(pin_override == 1'b1, "R10 override with action", pin_override, 1);

        // R7: toggle on match
        wr(0, 8'h19);
        wr(1, 8'h00);
        steps(3);
        chk(wave_out == 1'b0, "R7 toggle before match", wave_out, 0);
        steps(1);
        chk(wave_out == 1'b1, "R7 toggle first match", wave_out, 1);
        steps(4);
        chk(wave_out == 1'b0, "R7 toggle second match", wave_out, 0);
        // R9: force set
        wr(3, 8'h03);
        rd(1, v);
        wr(0, 8'hB9);
        chk(wave_out == 1'b1, "R9 force set", wave_out, 1);
        rd(1, v2);
        chk(v2 == v, "R9 force set leaves counter", v2, v);
        chk(cmp_irq == 1'b0, "R9 force set no flag", cmp_irq, 0);
        // R7: clear on match
        wr(0, 8'h29);
        wr(1, 8'h00);
        steps(4);
        chk(wave_out == 1'b0, "R7 clear on match", wave_out, 0);

        // R11: counter write suppresses next match
        wr(0, 8'h09);
        chk(pin_override == 1'b0, "R10 override off", pin_override, 0);
        wr(3, 8'h03);
        wr(1, 8'h03);
        steps(1);
        rd(1, v);
        chk(v == 8'h04, "R11 match blocked after write", v, 4);
        chk(cmp_irq == 1'b0, "R11 no flag after write", cmp_irq, 0);

        // R5/R6/R8: single-slope PWM, buffered compare loaded at wrap
        wr(0, 8'h69);
        wr(2, 8'h40);
        wr(1, 8'hF0);
        wr(3, 8'h03);
        steps(15);
        chk(ovf_irq == 1'b0, "R5 no overflow before 0xFF", ovf_irq, 0);
        steps(1);
        chk(ovf_irq == 1'b1, "R5 overflow at wrap", ovf_irq, 1);
        for (int k = 1; k <= 512; k++) begin
            steps(1);
            rd(1, v);
            chk(v == 8'(k % 256), "R5 single-slope count", v, k % 256);
            chk(wave_out == ((k % 256) <= 8'h40), "R8 single-slope wave", wave_out, (k % 256) <= 8'h40);
        end
        // R9: force ignored in PWM
        wr(0, 8'hE9);
        chk(wave_out == 1'b1, "R9 force ignored in PWM", wave_out, 1);
        rd(0, v);
        chk(v == 8'h69, "R9 force bit reads 0 in PWM", v, 8'h69);

        // R4/R6/R8: dual-slope PWM, compare loaded at top
        wr(0, 8'h61);
        wr(2, 8'h80);
        wr(1, 8'h00);
        wr(3, 8'h03);
        for (int k = 1; k <= 1020; k++) begin
            steps(1);
            rd(1, v);
            chk(v == 8'(dual_cnt(k)), "R4 dual-slope count", v, dual_cnt(k));
            if (k == 1) begin
                chk(ovf_irq == 1'b1, "R4 overflow leaving 0x00", ovf_irq, 1);
                wr(3, 8'h01);
            end
            if (k == 510) chk(ovf_irq == 1'b0, "R4 no overflow before bottom", ovf_irq, 0);
            if (k == 511) chk(ovf_irq == 1'b1, "R4 overflow at bottom", ovf_irq, 1);
            if (k >= 383) begin
                bit exp_w;
                exp_w = ((k % 510) <= 255) ? (dual_cnt(k) <= 8'h80) : (dual_cnt(k) <= 8'h7F);
                chk(wave_out == exp_w, "R8 dual-slope wave", wave_out, exp_w);
            end
        end

        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    localparam logic [1:0] ADDR_CNT_T = 2'd1;

    initial begin
        #(4 * 150000);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule